// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control state machine that takes a simple processor out of normal execution and into an interrupt handler. It watches one request line, which carries a 3-bit priority and a fast-class marker. It decides whether the request may be taken. It then waits for a safe point: the end of the current instruction, or the abort of a long block-transfer instruction that has been marked as suspendable.

Once a request is taken, the block runs a fixed list of steps, one per cycle:
- It reads the interrupt number over a memory read port and clears the pending bit of the source.
- It takes a snapshot of the flag word and clears three control flags in it.
- It saves the flag snapshot and the program counter. A normal entry pushes both through memory onto the interrupt stack. A fast entry writes them into dedicated save registers.
- It raises the current priority level.
- It loads the handler address into the program counter.

The block drives the register file through write strobes, each paired with a value. The total response time is the wait to the next safe point plus a fixed sequence length: 8 cycles for a normal entry and 7 for a fast entry.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only when flag bit 6 (interrupt enable) of `flags_in` is 1. A normal request must also have `req_lvl` strictly greater than `ipl_in`. A fast request (`req_fast`=1) skips the level comparison. A request that is not taken causes no strobe and leaves `busy` low.
- R2: While neither `insn_done` nor `insn_susp` is high, an eligible request is held off. The first sequence step (the acknowledge read) is issued in the cycle after the cycle in which the boundary is seen.
- R3: When an eligible request meets `insn_susp`=1 with `insn_done`=0, `insn_abort` is high in that same cycle, and the acknowledge read follows in the next cycle.
- R4: The acknowledge read uses address 0x00000000 for a normal entry and 0x00000002 for a fast entry. The read data arrives one cycle after `mem_rd`. Bits [5:0] of that data are the interrupt number.
- R5: `clr_pend` pulses in the cycle after the acknowledge read. In that cycle `clr_fast` is 1 only for a fast entry.
- R6: One cycle after `clr_pend`, `flags_we` writes the flag word sampled when the request was taken. In the written value, bit 7 (stack select), bit 6 (interrupt enable) and bit 4 (single step) are cleared and all other bits are unchanged.
- R7: A normal entry then writes the zero-extended flag snapshot to address `isp_in`-4. In the next cycle it writes the program counter to `isp_in`-8. Each of these write cycles also raises `isp_we`, with `isp_out` equal to the address just written.
- R8: A fast entry instead raises `svf_we` with the flag snapshot and then `svp_we` with the program counter. It makes no memory write and no `isp_we`.
- R9: After the saves, `ipl_we` writes `req_lvl` to `ipl_out`. A normal entry then reads the word at `vec_base_in` + 4×number and loads it into the program counter. A fast entry loads `fast_vec_in` with no read. `pc_we` marks the load.
- R10: `busy` is high from the acknowledge read through the cycle of the program-counter load, and is low after reset and after that cycle. `done` is high for exactly that one load cycle. The sequence lasts 8 cycles for a normal entry and 7 for a fast entry.
- R11: While `busy` is high, requests and boundary signals are ignored: `insn_abort` stays low and no second sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is pending |
| req_fast | input | 1 | The pending request is of the fast class |
| req_lvl | input | 3 | Priority of the pending request |
| insn_done | input | 1 | The current instruction completes this cycle |
| insn_susp | input | 1 | The current instruction may be suspended |
| insn_abort | output | 1 | Abort the suspendable instruction |
| flags_in | input | 16 | Current flag word |
| ipl_in | input | 3 | Current priority level |
| isp_in | input | 32 | Interrupt stack pointer |
| pc_in | input | 32 | Program counter to resume at |
| vec_base_in | input | 32 | Base address of the vector table |
| fast_vec_in | input | 32 | Handler address for the fast class |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| clr_pend | output | 1 | Clear the pending bit of the taken source |
| clr_fast | output | 1 | The bit to clear is the fast source's bit |
| flags_we | output | 1 | Flag word write strobe |
| flags_out | output | 16 | New flag word |
| isp_we | output | 1 | Stack pointer write strobe |
| isp_out | output | 32 | New stack pointer |
| svf_we | output | 1 | Flag save register write strobe |
| svf_out | output | 16 | Flag save value |
| svp_we | output | 1 | PC save register write strobe |
| svp_out | output | 32 | PC save value |
| ipl_we | output | 1 | Priority level write strobe |
| ipl_out | output | 3 | New priority level |
| pc_we | output | 1 | Program counter load strobe |
| pc_out | output | 32 | Handler address |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Sequence ends; execution resumes |

## Verification
The hardest situation to reach from the ports is a request that is still asserted, together with an active boundary signal, while a sequence is already running. A careless design would abort or restart there.

The stimulus holds `req_valid` and `insn_susp` high through every entry and releases them only in the `done` cycle. The scoreboard then confirms that `insn_abort` never rises and that no event appears beyond the expected list. Held-off requests are produced by keeping the boundary signals low for several cycles before asserting them. The equal-level case is also driven, to confirm that it is rejected.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int FLAG_W     = 16;
    localparam int LVL_W      = 3;
    localparam int NUM_W      = 6;
    localparam int PUSH_BYTES = 4;

    localparam int IE_BIT   = 6;
    localparam int STEP_BIT = 4;
    localparam int STK_BIT  = 7;

    localparam logic [ADDR_W-1:0] ACK_ADDR_NORM = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ACK_ADDR_FAST = ADDR_W'(2);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NUM,
        ST_NUMW,
        ST_FLG,
        ST_PSHF,
        ST_PSHP,
        ST_LVL,
        ST_VRD,
        ST_VLD
    } step_e;

    typedef struct packed {
        logic              fast;
        logic [LVL_W-1:0]  lvl;
        logic [FLAG_W-1:0] flags;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc;
        logic [NUM_W-1:0]  num;
    } ctx_t;

    function automatic logic [FLAG_W-1:0] entry_flags(input logic [FLAG_W-1:0] f);
        logic [FLAG_W-1:0] r;
        r = f;
        r[IE_BIT]   = 1'b0;
        r[STEP_BIT] = 1'b0;
        r[STK_BIT]  = 1'b0;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [NUM_W-1:0]  num);
        return base + ADDR_W'({num, 2'b00});
    endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_entry_pkg::*;
(
    input  logic             idle,
    input  logic             req_valid,
    input  logic             req_fast,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic [LVL_W-1:0] ipl,
    input  logic             ie,
    input  logic             insn_done,
    input  logic             insn_susp,
    output logic             take,
    output logic             abort
);

    logic eligible;
    logic at_boundary;

    always_comb begin
        eligible    = req_valid && ie && (req_fast || (req_lvl > ipl));
        at_boundary = insn_done || insn_susp;
        take        = idle && eligible && at_boundary;
        abort       = take && insn_susp && !insn_done;
    end

endmodule

// File: rtl/irq_step_fsm.sv
module irq_step_fsm
    import irq_entry_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  fast,
    output step_e state
);

    step_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (take) nxt = ST_NUM;
            ST_NUM:  nxt = ST_NUMW;
            ST_NUMW: nxt = ST_FLG;
            ST_FLG:  nxt = ST_PSHF;
            ST_PSHF: nxt = ST_PSHP;
            ST_PSHP: nxt = ST_LVL;
            ST_LVL:  nxt = fast ? ST_VLD : ST_VRD;
            ST_VRD:  nxt = ST_VLD;
            ST_VLD:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/irq_ctx.sv
module irq_ctx
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              req_fast,
    input  logic [LVL_W-1:0]  req_lvl,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [ADDR_W-1:0] isp_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  step_e             state,
    input  logic [NUM_W-1:0]  num_word,
    output ctx_t              ctx
);

    localparam logic [ADDR_W-1:0] STEP_DOWN = ADDR_W'(PUSH_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (take) begin
            ctx.fast  <= req_fast;
            ctx.lvl   <= req_lvl;
            ctx.flags <= flags_in;
            ctx.sp    <= isp_in;
            ctx.pc    <= pc_in;
            ctx.num   <= '0;
        end else begin
            if (state == ST_NUMW)
                ctx.num <= num_word;
            if (!ctx.fast && (state == ST_PSHF || state == ST_PSHP))
                ctx.sp <= ctx.sp - STEP_DOWN;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_fast,
    input  logic [LVL_W-1:0]  req_lvl,
    input  logic              insn_done,
    input  logic              insn_susp,
    output logic              insn_abort,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [LVL_W-1:0]  ipl_in,
    input  logic [ADDR_W-1:0] isp_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] vec_base_in,
    input  logic [ADDR_W-1:0] fast_vec_in,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              clr_pend,
    output logic              clr_fast,
    output logic              flags_we,
    output logic [FLAG_W-1:0] flags_out,
    output logic              isp_we,
    output logic [ADDR_W-1:0] isp_out,
    output logic              svf_we,
    output logic [FLAG_W-1:0] svf_out,
    output logic              svp_we,
    output logic [ADDR_W-1:0] svp_out,
    output logic              ipl_we,
    output logic [LVL_W-1:0]  ipl_out,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_out,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] STEP_DOWN = ADDR_W'(PUSH_BYTES);

    step_e state;
    ctx_t  ctx;
    logic  take;
    logic  idle;

    assign idle = (state == ST_IDLE);

    irq_accept u_accept (
        .idle      (idle),
        .req_valid (req_valid),
        .req_fast  (req_fast),
        .req_lvl   (req_lvl),
        .ipl       (ipl_in),
        .ie        (flags_in[IE_BIT]),
        .insn_done (insn_done),
        .insn_susp (insn_susp),
        .take      (take),
        .abort     (insn_abort)
    );

    irq_step_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .fast  (ctx.fast),
        .state (state)
    );

    irq_ctx u_ctx (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .req_fast (req_fast),
        .req_lvl  (req_lvl),
        .flags_in (flags_in),
        .isp_in   (isp_in),
        .pc_in    (pc_in),
        .state    (state),
        .num_word (mem_rdata[NUM_W-1:0]),
        .ctx      (ctx)
    );

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        clr_pend  = 1'b0;
        clr_fast  = 1'b0;
        flags_we  = 1'b0;
        flags_out = '0;
        isp_we    = 1'b0;
        isp_out   = '0;
        svf_we    = 1'b0;
        svf_out   = '0;
        svp_we    = 1'b0;
        svp_out   = '0;
        ipl_we    = 1'b0;
        ipl_out   = '0;
        pc_we     = 1'b0;
        pc_out    = '0;
        done      = 1'b0;
        busy      = !idle;
        unique case (state)
            ST_NUM: begin
                mem_rd   = 1'b1;
                mem_addr = ctx.fast ? ACK_ADDR_FAST : ACK_ADDR_NORM;
            end
            ST_NUMW: begin
                clr_pend = 1'b1;
                clr_fast = ctx.fast;
            end
            ST_FLG: begin
                flags_we  = 1'b1;
                flags_out = entry_flags(ctx.flags);
            end
            ST_PSHF: begin
                if (ctx.fast) begin
                    svf_we  = 1'b1;
                    svf_out = ctx.flags;
                end else begin
                    mem_wr    = 1'b1;
                    mem_addr  = ctx.sp - STEP_DOWN;
                    mem_wdata = DATA_W'(ctx.flags);
                    isp_we    = 1'b1;
                    isp_out   = ctx.sp - STEP_DOWN;
                end
            end
            ST_PSHP: begin
                if (ctx.fast) begin
                    svp_we  = 1'b1;
                    svp_out = ctx.pc;
                end else begin
                    mem_wr    = 1'b1;
                    mem_addr  = ctx.sp - STEP_DOWN;
                    mem_wdata = DATA_W'(ctx.pc);
                    isp_we    = 1'b1;
                    isp_out   = ctx.sp - STEP_DOWN;
                end
            end
            ST_LVL: begin
                ipl_we  = 1'b1;
                ipl_out = ctx.lvl;
            end
            ST_VRD: begin
                mem_rd   = 1'b1;
                mem_addr = vec_addr(vec_base_in, ctx.num);
            end
            ST_VLD: begin
                pc_we  = 1'b1;
                done   = 1'b1;
                pc_out = ctx.fast ? fast_vec_in : ADDR_W'(mem_rdata);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_fast,
    input logic [LVL_W-1:0]  req_lvl,
    input logic [LVL_W-1:0]  ipl_in,
    input logic              ie_in,
    input logic              insn_done,
    input logic              insn_susp,
    input logic              insn_abort,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              clr_pend,
    input logic              flags_we,
    input logic [2:0]        ctl_bits,
    input logic              svf_we,
    input logic              svp_we,
    input logic              ipl_we,
    input logic              pc_we,
    input logic              busy,
    input logic              done
);

    // R1
    ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ie_in));

    // R1
    level_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(req_fast)) |-> ($past(req_lvl) > $past(ipl_in)));

    // R2
    boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(insn_done || insn_susp));

    // R3
    abort_start_chk: assert property (@(posedge clk) disable iff (rst)
        insn_abort |=> busy);

    // R3
    abort_susp_chk: assert property (@(posedge clk) disable iff (rst)
        insn_abort |-> insn_susp);

    // R4
    ack_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_rd && mem_addr == ($past(req_fast) ? ACK_ADDR_FAST : ACK_ADDR_NORM)));

    // R5
    clr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> clr_pend);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (ctl_bits == 3'b000));

    // R8
    fast_pair_chk: assert property (@(posedge clk) disable iff (rst)
        svf_we |=> (svp_we && !mem_wr));

    // R9
    ipl_first_chk: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> ($past(ipl_we) || $past(ipl_we, 2)));

    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    done_load_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_we && busy));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !insn_abort);

endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_fast   (req_fast),
    .req_lvl    (req_lvl),
    .ipl_in     (ipl_in),
    .ie_in      (flags_in[irq_entry_pkg::IE_BIT]),
    .insn_done  (insn_done),
    .insn_susp  (insn_susp),
    .insn_abort (insn_abort),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .clr_pend   (clr_pend),
    .flags_we   (flags_we),
    .ctl_bits   ({flags_out[irq_entry_pkg::STK_BIT], flags_out[irq_entry_pkg::IE_BIT], flags_out[irq_entry_pkg::STEP_BIT]}),
    .svf_we     (svf_we),
    .svp_we     (svp_we),
    .ipl_we     (ipl_we),
    .pc_we      (pc_we),
    .busy       (busy),
    .done       (done)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    localparam int EV_RD  = 0;
    localparam int EV_CLR = 1;
    localparam int EV_FLG = 2;
    localparam int EV_WR  = 3;
    localparam int EV_ISP = 4;
    localparam int EV_SVF = 5;
    localparam int EV_SVP = 6;
    localparam int EV_IPL = 7;
    localparam int EV_PC  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_fast = 1'b0;
    logic [2:0]  req_lvl = '0;
    logic        insn_done = 1'b0, insn_susp = 1'b0;
    logic        insn_abort;
    logic [15:0] flags_in = '0;
    logic [2:0]  ipl_in = '0;
    logic [31:0] isp_in = '0, pc_in = '0, vec_base_in = '0, fast_vec_in = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        clr_pend, clr_fast, flags_we, isp_we, svf_we, svp_we, ipl_we, pc_we, busy, done;
    logic [15:0] flags_out, svf_out;
    logic [31:0] isp_out, svp_out, pc_out;
    logic [2:0]  ipl_out;

    int errors = 0;
    int checks = 0;
    logic [5:0] norm_num = '0;
    logic [5:0] fast_num = '0;

    int          exp_kind[$];
    logic [31:0] exp_a[$];
    logic [31:0] exp_b[$];
    string       exp_tag[$];

    always #10 clk = ~clk;

    irq_entry_seq u_dut (.*);

    always @(posedge clk) begin
        if (mem_rd) begin
            if (mem_addr == 32'h0)      mem_rdata <= 32'hFFFF_FFC0 | {26'd0, norm_num};
            else if (mem_addr == 32'h2) mem_rdata <= 32'hFFFF_FFC0 | {26'd0, fast_num};
            else                        mem_rdata <= {8'hA5, mem_addr[23:0]};
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_kind.push_back(k);
        exp_a.push_back(a);
        exp_b.push_back(b);
        exp_tag.push_back(tag);
    endtask

    task automatic observe(input int k, input logic [31:0] a, input logic [31:0] b);
        int ek; logic [31:0] ea, eb; string t;
        if (exp_kind.size() == 0) begin
            check(1'b0, $sformatf("R11 unexpected event kind %0d", k), a, 32'h0);
        end else begin
            ek = exp_kind.pop_front();
            ea = exp_a.pop_front();
            eb = exp_b.pop_front();
            t  = exp_tag.pop_front();
            check(ek == k && ea == a && eb == b,
                  $sformatf("%s event kind %0d (expected kind %0d) second=%h/%h", t, k, ek, b, eb), a, ea);
        end
    endtask

    // Scoreboard monitor: strobes in a fixed per-cycle order
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (mem_rd)   observe(EV_RD, mem_addr, 32'h0);
                if (clr_pend) observe(EV_CLR, {31'd0, clr_fast}, 32'h0);
                if (flags_we) observe(EV_FLG, {16'd0, flags_out}, 32'h0);
                if (mem_wr)   observe(EV_WR, mem_addr, mem_wdata);
                if (isp_we)   observe(EV_ISP, isp_out, 32'h0);
                if (svf_we)   observe(EV_SVF, {16'd0, svf_out}, 32'h0);
                if (svp_we)   observe(EV_SVP, svp_out, 32'h0);
                if (ipl_we)   observe(EV_IPL, {29'd0, ipl_out}, 32'h0);
                if (pc_we)    observe(EV_PC, pc_out, 32'h0);
            end
        end
    end

    task automatic entry(input bit fast, input logic [2:0] lvl, input logic [2:0] ipl,
                         input logic [15:0] fl, input logic [31:0] isp, input logic [31:0] pc,
                         input logic [31:0] vb, input logic [31:0] fv, input logic [5:0] num,
                         input bit susp, input int waitc);
        logic [31:0] vaddr;
        int n;
        bit ab;
        @(negedge clk);
        flags_in = fl; ipl_in = ipl; isp_in = isp; pc_in = pc;
        vec_base_in = vb; fast_vec_in = fv;
        if (fast) fast_num = num; else norm_num = num;
        vaddr = vb + {24'd0, num, 2'b00};
        push(EV_RD, fast ? 32'h2 : 32'h0, 32'h0, "R4");
        push(EV_CLR, {31'd0, fast}, 32'h0, "R5");
        push(EV_FLG, {16'd0, fl & ~16'h00D0}, 32'h0, "R6");
        if (!fast) begin
            push(EV_WR, isp - 32'd4, {16'd0, fl}, "R7");
            push(EV_ISP, isp - 32'd4, 32'h0, "R7");
            push(EV_WR, isp - 32'd8, pc, "R7");
            push(EV_ISP, isp - 32'd8, 32'h0, "R7");
        end else begin
            push(EV_SVF, {16'd0, fl}, 32'h0, "R8");
            push(EV_SVP, pc, 32'h0, "R8");
        end
        push(EV_IPL, {29'd0, lvl}, 32'h0, "R9");
        if (!fast) push(EV_RD, vaddr, 32'h0, "R9");
        push(EV_PC, fast ? fv : {8'hA5, vaddr[23:0]}, 32'h0, "R9");

        req_valid = 1'b1; req_fast = fast; req_lvl = lvl;
        insn_done = 1'b0; insn_susp = 1'b0;
        for (int i = 0; i < waitc; i++) begin
            @(negedge clk);
            #1;
            check(busy == 1'b0 && mem_rd == 1'b0, "R2 held off before boundary", {31'd0, busy}, 32'h0);
        end
        insn_done = !susp;
        insn_susp = susp;
        #1;
        check(insn_abort == susp, "R3 abort in boundary cycle", {31'd0, insn_abort}, {31'd0, susp});
        n = 0;
        ab = 1'b0;
        while (n < 20) begin
            @(negedge clk);
            #1;
            n++;
            insn_done = 1'b0;
            insn_susp = 1'b1;
            #1;
            if (insn_abort) ab = 1'b1;
            if (!busy) break;
            if (done) break;
        end
        req_valid = 1'b0; insn_susp = 1'b0; insn_done = 1'b0;
        check(done == 1'b1 && n == (fast ? 7 : 8), "R10 sequence length to done",
              n, fast ? 32'd7 : 32'd8);
        check(ab == 1'b0, "R11 no abort while busy", {31'd0, ab}, 32'h0);
        @(negedge clk);
        #1;
        check(busy == 1'b0 && done == 1'b0, "R10 busy low after load", {31'd0, busy}, 32'h0);
        @(negedge clk);
        #3;
        check(exp_kind.size() == 0, "R9 all expected events seen", exp_kind.size(), 32'h0);
    endtask

    task automatic reject(input bit fast, input logic [2:0] lvl, input logic [2:0] ipl,
                          input logic [15:0] fl, input string what);
        @(negedge clk);
        flags_in = fl; ipl_in = ipl;
        req_valid = 1'b1; req_fast = fast; req_lvl = lvl;
        insn_done = 1'b1; insn_susp = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check(busy == 1'b0 && mem_rd == 1'b0, what, {31'd0, busy}, 32'h0);
        end
        req_valid = 1'b0; insn_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {30'd0, busy, done}, 32'h0);
        check(mem_rd == 1'b0 && mem_wr == 1'b0, "R10 reset memory strobes", {30'd0, mem_rd, mem_wr}, 32'h0);
        rst = 1'b0;

        // R2/R7: normal entry after an ordinary instruction, with a wait
        entry(1'b0, 3'd5, 3'd2, 16'hFFFF, 32'h0000_1000, 32'h0000_4321,
              32'h0000_0200, 32'h0000_9000, 6'd9, 1'b0, 2);
        // R3: normal entry suspending a block instruction
        entry(1'b0, 3'd3, 3'd2, 16'h00D0, 32'h0000_0800, 32'h0001_0000,
              32'h0000_0400, 32'h0000_9000, 6'd1, 1'b1, 0);
        // R8/R1: fast entry below the current level
        entry(1'b1, 3'd0, 3'd7, 16'h1F5A, 32'h0000_2000, 32'h0000_7777,
              32'h0000_0200, 32'h00AB_CD00, 6'd17, 1'b0, 1);
        // R8/R3: fast entry with suspend
        entry(1'b1, 3'd6, 3'd1, 16'h0040, 32'h0000_3000, 32'h0000_0010,
              32'h0000_0200, 32'h0000_5550, 6'd0, 1'b1, 0);
        // R1: rejections
        reject(1'b0, 3'd7, 3'd0, 16'hFFBF, "R1 interrupt enable clear");
        reject(1'b1, 3'd7, 3'd0, 16'h0000, "R1 fast needs enable");
        reject(1'b0, 3'd4, 3'd4, 16'h0040, "R1 equal level rejected");
        reject(1'b0, 3'd2, 3'd5, 16'h0040, "R1 lower level rejected");
        // R9: highest level and largest number
        entry(1'b0, 3'd7, 3'd6, 16'h0041, 32'h0000_0010, 32'h0000_ABCD,
              32'hFFFF_FF00, 32'h0000_9000, 6'd63, 1'b0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

endmodule